// File: doc/BRIEF.md
# Dithered Fine-Resolution PWM Converter

This block turns a 24-bit control word into a single-bit pulse stream. A low-pass filter outside the chip turns that stream into a steady analog level. The native pulse width has only 10 bits of resolution. The remaining 14 bits are recovered by first-order dithering: each frame, the fraction is added into a running accumulator, and every time that accumulator wraps, the pulse of the following frame is one clock longer. Averaged over many frames, the duty cycle equals the full 24-bit value. Because of that, the external filter sees a level far finer than one clock step of the frame.

A signed trim input is summed with the control word before it is split into coarse and fine parts. The sum is clamped so that it can never call for a negative width or for more than a full frame. Both inputs are taken only at frame boundaries, so software may change them at any time without disturbing a pulse already in progress. A one-clock strobe marks the first clock of every frame, which lets a controller pace its updates to the frame rate.

Top module: `dither_pwm_dac`

## Requirements
- R1: A frame lasts exactly FRAME_CLKS clocks (1000 by default). `frame_strobe` is high for exactly one clock, in the first clock of each frame, and is low in every other clock.
- R2: Within a frame, `pwm_out` is high for the first W clocks and low for the remaining FRAME_CLKS−W clocks. It rises only in the clock that carries `frame_strobe`.
- R3: The effective word is split into a coarse part and a fraction. The coarse part is bits [23:14] of the effective word. When no carry occurs, the width W of a frame equals this coarse value.
- R4: At every frame boundary, the fraction (bits [13:0] of the effective word) is added into a 14-bit accumulator. A carry out of bit 13 makes the next frame's width the coarse value plus one.
- R5: While the word is held constant, the frame widths average to the exact word. For a fraction of 0x1000, any four consecutive frames together contain exactly one lengthened frame.
- R6: `target_word` and `trim_offset` are sampled only at the frame boundary. A change made in mid-frame leaves the current frame's width untouched and takes effect in the next frame.
- R7: The width never exceeds FRAME_CLKS. A coarse value that would reach past a full frame gives a pulse that stays high for the whole frame.
- R8: The effective word is `target_word` plus the sign-extended two's-complement `trim_offset`. The sum is clamped to the range 0 to FRAME_CLKS·2^14.
- R9: While `rst_n` is low, `pwm_out` and `frame_strobe` are low, and the accumulator and the width are cleared. The first frame after reset has width 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| target_word | input | 24 | Control word: coarse width in the upper 10 bits, fraction in the lower 14 bits |
| trim_offset | input | 16 | Signed correction added to the control word before it is split |
| pwm_out | output | 1 | Dithered pulse stream |
| frame_strobe | output | 1 | One-clock marker on the first clock of each frame |

## Verification
The hardest case to reach from the ports is the carry itself. The lengthened pulse appears one frame after the accumulator wraps, and whether it wraps depends on every fraction added since reset. The bench therefore keeps its own running fraction across all stimulus rows. It also resets the block in mid-run to pin the accumulator at zero, and then checks the exact sequence that follows. Sampling only at the boundary is provoked by changing the word in the middle of a frame and measuring both that frame and the next one. Saturation and clamping are reached with words and offsets that push the sum past each end of the range.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  // Limit a signed sum to the closed range [0, hi].
  function automatic longint clamp_word(input longint value, input longint hi);
    if (value < 0) return 0;
    if (value > hi) return hi;
    return value;
  endfunction

  // Coarse width plus an optional carry step, held at the frame length.
  function automatic int sat_width(input int coarse, input logic carry, input int limit);
    int w;
    w = coarse + (carry ? 1 : 0);
    return (w > limit) ? limit : w;
  endfunction

endpackage

// File: rtl/dpwm_frame_timer.sv
module dpwm_frame_timer #(
  parameter int FRAME_CLKS = 1000,
  localparam int CNT_W = $clog2(FRAME_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] phase,
  output logic             frame_first,
  output logic             frame_wrap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CLKS - 1);

  logic [CNT_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase_q <= '0;
    else if (phase_q == LAST)   phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  assign phase       = phase_q;
  assign frame_first = (phase_q == '0);
  assign frame_wrap  = (phase_q == LAST);
endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither
  import dpwm_pkg::*;
#(
  parameter int FRAME_CLKS = 1000,
  parameter int COARSE_W   = 10,
  parameter int FRAC_W     = 14,
  parameter int OFS_W      = 16,
  localparam int WORD_W    = COARSE_W + FRAC_W,
  localparam int WID_W     = $clog2(FRAME_CLKS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [WORD_W-1:0]       target,
  input  logic signed [OFS_W-1:0] offset,
  output logic [WID_W-1:0]        width_q,
  output logic [FRAC_W-1:0]       acc_q,
  output logic                    carry
);
  localparam longint MAX_WORD = longint'(FRAME_CLKS) << FRAC_W;

  logic [WORD_W-1:0]   eff_word;
  logic [COARSE_W-1:0] coarse;
  logic [FRAC_W-1:0]   frac;
  logic [FRAC_W:0]     acc_sum;
  logic [WID_W-1:0]    width_next;

  always_comb begin
    eff_word   = WORD_W'(clamp_word(longint'(target) + longint'(offset), MAX_WORD));
    coarse     = eff_word[WORD_W-1:FRAC_W];
    frac       = eff_word[FRAC_W-1:0];
    acc_sum    = {1'b0, acc_q} + {1'b0, frac};
    carry      = acc_sum[FRAC_W];
    width_next = WID_W'(sat_width(int'(coarse), carry, FRAME_CLKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      width_q <= '0;
    end else if (load) begin
      acc_q   <= acc_sum[FRAC_W-1:0];
      width_q <= width_next;
    end
  end
endmodule

// File: rtl/dpwm_pulse_gen.sv
module dpwm_pulse_gen #(
  parameter int FRAME_CLKS = 1000,
  localparam int CNT_W = $clog2(FRAME_CLKS),
  localparam int WID_W = $clog2(FRAME_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] phase,
  input  logic             frame_first,
  input  logic [WID_W-1:0] width,
  output logic             pwm_q,
  output logic             strobe_q
);
  logic high_now;

  assign high_now = int'(phase) < int'(width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      pwm_q    <= high_now;
      strobe_q <= frame_first;
    end
  end
endmodule

// File: rtl/dither_pwm_dac.sv
module dither_pwm_dac #(
  parameter int FRAME_CLKS = 1000,
  parameter int COARSE_W   = 10,
  parameter int FRAC_W     = 14,
  parameter int OFS_W      = 16,
  localparam int WORD_W    = COARSE_W + FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WORD_W-1:0]       target_word,
  input  logic signed [OFS_W-1:0] trim_offset,
  output logic                    pwm_out,
  output logic                    frame_strobe
);
  localparam int CNT_W = $clog2(FRAME_CLKS);
  localparam int WID_W = $clog2(FRAME_CLKS + 1);

  logic [CNT_W-1:0]  phase;
  logic              frame_first;
  logic              frame_wrap;
  logic [WID_W-1:0]  width_q;
  logic [FRAC_W-1:0] acc_q;
  logic              carry;

  dpwm_frame_timer #(.FRAME_CLKS(FRAME_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .frame_first(frame_first), .frame_wrap(frame_wrap)
  );

  dpwm_dither #(
    .FRAME_CLKS(FRAME_CLKS), .COARSE_W(COARSE_W),
    .FRAC_W(FRAC_W), .OFS_W(OFS_W)
  ) u_dither (
    .clk(clk), .rst_n(rst_n), .load(frame_wrap),
    .target(target_word), .offset(trim_offset),
    .width_q(width_q), .acc_q(acc_q), .carry(carry)
  );

  dpwm_pulse_gen #(.FRAME_CLKS(FRAME_CLKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .phase(phase), .frame_first(frame_first),
    .width(width_q), .pwm_q(pwm_out), .strobe_q(frame_strobe)
  );
endmodule

// File: rtl/dither_pwm_dac_chk.sv
module dither_pwm_dac_chk #(
  parameter int FRAME_CLKS = 1000,
  parameter int FRAC_W     = 14,
  localparam int WID_W     = $clog2(FRAME_CLKS + 1),
  localparam int GAP_W     = $clog2(FRAME_CLKS) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe,
  input logic              pwm,
  input logic              frame_wrap,
  input logic [WID_W-1:0]  width,
  input logic [FRAC_W-1:0] acc
);
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (strobe) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assert_strobe_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (!seen_q || int'(gap_q) == FRAME_CLKS - 1));

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  assert_pwm_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm) |-> strobe);

  assert_acc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(acc));

  assert_width_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(width));

  assert_width_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(width) <= FRAME_CLKS);
endmodule

bind dither_pwm_dac dither_pwm_dac_chk #(
  .FRAME_CLKS(FRAME_CLKS), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(frame_strobe), .pwm(pwm_out),
  .frame_wrap(frame_wrap), .width(width_q), .acc(acc_q)
);

// File: tb/tb_dither_pwm_dac.sv
module tb_dither_pwm_dac;
  localparam int FRAME = 1000;
  localparam int ONE   = 16384;

  typedef struct packed {
    logic [23:0] tgt;
    logic [15:0] ofs;
    logic [7:0]  nfr;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{24'h190000, 16'h0000, 8'd3},   // 100 flat
    '{24'h3EA000, 16'h0000, 8'd4},   // 250 + 1/2
    '{24'h01D000, 16'h0000, 8'd4},   // 7 + 1/4
    '{24'h000000, 16'h0000, 8'd2},   // zero
    '{24'hFFFFFF, 16'h0000, 8'd2},   // above range, clamp
    '{24'hF9FFFF, 16'h0000, 8'd3},   // 999 + almost one
    '{24'h190000, 16'hFFFF, 8'd3},   // minus one LSB
    '{24'h000005, 16'hFF9C, 8'd2},   // negative sum
    '{24'hF8C000, 16'h7FFF, 8'd2},   // 995 + large trim
    '{24'h0A4800, 16'h0123, 8'd4}    // odd fraction
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] target_word = '0;
  logic [15:0] trim_offset = '0;
  logic        pwm_out;
  logic        frame_strobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int m_acc  = 0;
  int m_width = 0;

  always #4 clk = ~clk;

  dither_pwm_dac dut (
    .clk(clk), .rst_n(rst_n), .target_word(target_word),
    .trim_offset(trim_offset), .pwm_out(pwm_out), .frame_strobe(frame_strobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Reference: arithmetic on whole numbers, division instead of bit slicing.
  task automatic model_next(input logic [23:0] t, input logic [15:0] o);
    int s;
    int coarse;
    int w;
    s = int'(t) + int'($signed(o));
    if (s < 0) s = 0;
    if (s > FRAME * ONE) s = FRAME * ONE;
    coarse = s / ONE;
    m_acc  = m_acc + (s % ONE);
    w = coarse;
    if (m_acc >= ONE) begin
      m_acc = m_acc - ONE;
      w = w + 1;
    end
    if (w > FRAME) w = FRAME;
    m_width = w;
  endtask

  // Called at the negedge where frame_strobe is high; returns there for the next frame.
  task automatic run_frame(input logic [23:0] t0, input logic [15:0] o0, input bit mid,
                           input logic [23:0] t1, input logic [15:0] o1,
                           input string tag, output int meas);
    int  exp_w;
    bit  fell;
    bit  shape_ok;
    bit  extra_strobe;
    exp_w = m_width;
    fell = 1'b0;
    shape_ok = 1'b1;
    extra_strobe = 1'b0;
    meas = 0;
    for (int i = 0; i < FRAME; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 0) begin target_word = t0; trim_offset = o0; end
      if (mid && i == FRAME / 2) begin target_word = t1; trim_offset = o1; end
      if (pwm_out) begin
        meas++;
        if (fell) shape_ok = 1'b0;
      end else begin
        fell = 1'b1;
      end
      if (i > 0 && frame_strobe) extra_strobe = 1'b1;
    end
    @(negedge clk);
    check(frame_strobe && !extra_strobe, "R1 strobe once per frame", int'(frame_strobe), 1);
    check(shape_ok, "R2 high then low", int'(shape_ok), 1);
    check(meas == exp_w, tag, meas, exp_w);
    if (mid) model_next(t1, o1);
    else     model_next(t0, o0);
  endtask

  task automatic align_after_reset();
    int guard;
    guard = 0;
    @(negedge clk);
    while (!frame_strobe && guard < 10) begin
      @(negedge clk);
      guard++;
    end
    check(frame_strobe, "R9 first strobe after reset", int'(frame_strobe), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    report();
  end

  initial begin
    int m;
    int sum4;
    // R9: reset state
    repeat (3) @(negedge clk);
    check(!pwm_out && !frame_strobe, "R9 outputs low in reset", int'(pwm_out), 0);
    target_word = 24'h190000;
    rst_n = 1'b1;
    m_acc = 0;
    m_width = 0;
    align_after_reset();
    run_frame(24'h190000, 16'h0000, 1'b0, '0, '0, "R9 first frame width", m);
    check(m == 0, "R9 first frame is empty", m, 0);

    // Vector table: R3 R4 R8 over varied words
    foreach (VECS[k]) begin
      for (int f = 0; f < int'(VECS[k].nfr); f++)
        run_frame(VECS[k].tgt, VECS[k].ofs, 1'b0, '0, '0, "R3 R4 vector width", m);
    end

    // R7: saturation, coarse fraction zero so no dependence on accumulator
    run_frame(24'hFFFFFF, 16'h0000, 1'b0, '0, '0, "R7 setup", m);
    run_frame(24'hFFFFFF, 16'h0000, 1'b0, '0, '0, "R7 width", m);
    check(m == FRAME, "R7 full-frame high", m, FRAME);

    // R8: negative trim gives 99 exactly; negative sum clamps to 0; positive clamps to full
    run_frame(24'h190000, 16'hC000, 1'b0, '0, '0, "R8 setup", m);
    run_frame(24'h000005, 16'hFF9C, 1'b0, '0, '0, "R8 width", m);
    check(m == 99, "R8 offset minus one coarse step", m, 99);
    run_frame(24'hF9C000, 16'h7FFF, 1'b0, '0, '0, "R8 width", m);
    check(m == 0, "R8 clamp at zero", m, 0);
    run_frame(24'h190000, 16'h0000, 1'b0, '0, '0, "R8 width", m);
    check(m == FRAME, "R8 clamp at top", m, FRAME);

    // R6: mid-frame change does not alter current pulse, applies next frame
    run_frame(24'hC80000, 16'h0000, 1'b1, 24'h050000, 16'h0000, "R6 current frame kept", m);
    check(m == 100, "R6 width unchanged by mid-frame write", m, 100);
    run_frame(24'h050000, 16'h0000, 1'b0, '0, '0, "R6 next frame", m);
    check(m == 20, "R6 mid-frame value applied next frame", m, 20);

    // R9 + R4: reset in mid-run clears accumulator, exact carry sequence afterwards
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!pwm_out && !frame_strobe, "R9 outputs low in second reset", int'(pwm_out), 0);
    target_word = 24'h4B2000;
    trim_offset = '0;
    rst_n = 1'b1;
    m_acc = 0;
    m_width = 0;
    align_after_reset();
    run_frame(24'h4B2000, 16'h0000, 1'b0, '0, '0, "R9 width after reset", m);
    check(m == 0, "R9 empty frame after reset", m, 0);
    run_frame(24'h4B2000, 16'h0000, 1'b0, '0, '0, "R4 no carry", m);
    check(m == 300, "R4 half fraction first add no carry", m, 300);
    run_frame(24'h4B2000, 16'h0000, 1'b0, '0, '0, "R4 carry", m);
    check(m == 301, "R4 second add carries", m, 301);
    run_frame(24'h01D000, 16'h0000, 1'b0, '0, '0, "R3 no carry", m);
    check(m == 300, "R3 coarse value without carry", m, 300);

    // R5: four consecutive frames with fraction 1/4 contain one extra clock
    sum4 = 0;
    for (int f = 0; f < 4; f++) begin
      run_frame(24'h01D000, 16'h0000, 1'b0, '0, '0, "R5 frame width", m);
      sum4 += m;
    end
    check(sum4 == 4 * 7 + 1, "R5 average over four frames", sum4, 29);

    report();
  end
endmodule